// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock and the bit-phase strobes for an I2C master from a fast source clock. One SCL half period is built from three nested counts: a fixed prescaler of `CLK_DIV` source clocks, a programmable sample count (1 to 8 prescaled ticks per step) and a programmable step count (steps per half period). A full SCL period therefore lasts `2 * CLK_DIV * sample * step` source clocks. Both counts are written to registers as the value minus one.

Two timing words are kept. The normal word serves standard and fast mode. The high-speed word serves high-speed mode, and its two low bits act as the enable. While high-speed mode is enabled, the normal word holds the slower timing used to send the master code that precedes a high-speed transfer. A bit engine drives `run_i`, samples SDA on `sample_stb_o` and changes SDA on `drive_stb_o`. At every run start the block also latches a start-condition setup word that suits the bus rate.

Register writes may arrive at any time. The counts and the setup word are captured only when a run starts, so a transfer in progress keeps its timing.

Top module: `i2c_scl_timing`

## Requirements
- R1: After reset `scl_o` is 1, `busy_o`, `sample_stb_o`, `drive_stb_o` and `hs_active_o` are 0, and a run started without any register write uses sample = step = 1.
- R2: With `cfg_sel_i`=0 the write goes to the normal word, where bits [10:8] hold sample−1 and bits [5:0] hold step−1. In normal mode the first SCL high phase begins in the first cycle with `busy_o`=1 and lasts `CLK_DIV*sample*step` cycles.
- R3: Each following SCL low and high phase lasts the same `CLK_DIV*sample*step` cycles.
- R4: With `cfg_sel_i`=1 the write goes to the high-speed word. When its bits [1:0] equal 2'b11 and `master_code_i` is 0 at run start, the counts come from bits [14:12] (sample−1) and [10:8] (step−1), and `hs_active_o` is 1 for the run.
- R5: When the high-speed word's bits [1:0] are not 2'b11 (for example the value 0), the normal word is used and `hs_active_o` is 0.
- R6: When high-speed mode is enabled and `master_code_i` is 1 at run start, the normal word sets the timing (preamble) and `hs_active_o` is 0.
- R7: `sample_stb_o` pulses for one cycle, only while SCL is high, `CLK_DIV*sample*floor(step/2)` cycles after the high phase begins.
- R8: `drive_stb_o` pulses for one cycle, in the second cycle of every SCL low phase.
- R9: A register write while `busy_o` is 1 does not change the running timing. It takes effect at the next run start.
- R10: `start_cfg_o` is latched at run start: 16'h8001 when `std_rate_i` is 1 (100 kHz or slower), otherwise 16'h1800.
- R11: When `run_i` is 0 at the end of a half period, the run ends: `busy_o` falls and `scl_o` is 1 (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Timing register write strobe |
| cfg_sel_i | input | 1 | 0 = normal word, 1 = high-speed word |
| cfg_wdata_i | input | 16 | Write data |
| run_i | input | 1 | Request SCL generation; drop to stop at the next half-period boundary |
| master_code_i | input | 1 | Use preamble timing in high-speed mode (sampled at run start) |
| std_rate_i | input | 1 | Bus runs at 100 kHz or slower (sampled at run start) |
| scl_o | output | 1 | Serial clock level (1 = released) |
| busy_o | output | 1 | Generator running |
| sample_stb_o | output | 1 | SDA sample strobe, middle of the high phase |
| drive_stb_o | output | 1 | SDA drive strobe, one clock after the falling edge |
| hs_active_o | output | 1 | High-speed counts in use for this run |
| start_cfg_o | output | 16 | Start-condition setup word for the bus engine |

## Verification
An error in the sample or step counter, or in the field decode, shows up first as a wrong length of the initial SCL high phase, so the bench times every phase to the exact cycle. A misplaced midpoint compare moves `sample_stb_o` away from its computed offset within the first high phase. A capture that follows register writes during a run shows up at the next SCL edge, because the phase length changes. A bad mode decode shows up in the first cycle of a run on `hs_active_o` and `start_cfg_o`, and soon after in the phase length.

// File: rtl/i2c_tg_pkg.sv
// Package: shared constants, count type and field decoders for the
// SCL timing generator. Field positions follow the register formats
// that the bit engine's software programs.
package i2c_tg_pkg;

    localparam int SMP_LIM_W = 4;   // sample count 1..8
    localparam int STP_LIM_W = 7;   // step count 1..64
    localparam int WORD_W    = 16;

    localparam logic [WORD_W-1:0] START_CFG_STD  = 16'h8001;
    localparam logic [WORD_W-1:0] START_CFG_FAST = 16'h1800;
    localparam logic [1:0]        HS_ENABLE_CODE = 2'b11;

    typedef struct packed {
        logic [SMP_LIM_W-1:0] smp;  // samples per step
        logic [STP_LIM_W-1:0] stp;  // steps per half period
    } tg_counts_t;

    // Normal word: sample-1 in [10:8], step-1 in [5:0].
    function automatic tg_counts_t decode_norm(input logic [WORD_W-1:0] w);
        tg_counts_t c;
        c.smp = {1'b0, w[10:8]} + 4'd1;
        c.stp = {1'b0, w[5:0]} + 7'd1;
        return c;
    endfunction

    // High-speed word: sample-1 in [14:12], step-1 in [10:8].
    function automatic tg_counts_t decode_hs(input logic [WORD_W-1:0] w);
        tg_counts_t c;
        c.smp = {1'b0, w[14:12]} + 4'd1;
        c.stp = {4'b0, w[10:8]} + 7'd1;
        return c;
    endfunction

endpackage

// File: rtl/tg_cfg_regs.sv
// Timing register file. Holds the two programmed timing words and, on
// each run start, captures the counts, the mode and the start-condition
// setup word that stay fixed for the whole run.
// Assumes: load_i is a single-cycle pulse given only while idle.
module tg_cfg_regs
    import i2c_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              master_code_i,
    input  logic              std_rate_i,
    input  logic              load_i,
    output tg_counts_t        cnt_o,
    output logic              hs_active_o,
    output logic [WORD_W-1:0] start_cfg_o
);

    logic [WORD_W-1:0] norm_word_q;
    logic [WORD_W-1:0] hs_word_q;
    logic              hs_enabled;
    logic              use_hs;
    tg_counts_t        next_cnt;

    // Programmed words: written at any time, read only at run start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            norm_word_q <= '0;
            hs_word_q   <= '0;
        end else if (cfg_we_i) begin
            if (cfg_sel_i) hs_word_q   <= cfg_wdata_i;
            else           norm_word_q <= cfg_wdata_i;
        end
    end

    // Mode select: high-speed counts unless disabled or sending the preamble.
    always_comb begin
        hs_enabled = (hs_word_q[1:0] == HS_ENABLE_CODE);
        use_hs     = hs_enabled && !master_code_i;
        next_cnt   = use_hs ? decode_hs(hs_word_q) : decode_norm(norm_word_q);
    end

    // Run-start capture of counts, mode flag and setup word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o       <= '{smp: 4'd1, stp: 7'd1};
            hs_active_o <= 1'b0;
            start_cfg_o <= START_CFG_FAST;
        end else if (load_i) begin
            cnt_o       <= next_cnt;
            hs_active_o <= use_hs;
            start_cfg_o <= std_rate_i ? START_CFG_STD : START_CFG_FAST;
        end
    end

endmodule

// File: rtl/tg_prescale.sv
// Fixed prescaler: emits one tick every CLK_DIV source clocks while
// enabled and reports when it sits at phase zero.
// Assumes: held cleared (en_i low) while the generator is idle.
module tg_prescale #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o,
    output logic zero_o
);

    generate
        if (CLK_DIV <= 1) begin : g_direct
            // No division: every enabled clock is a tick.
            always_comb begin
                tick_o = en_i;
                zero_o = 1'b1;
            end
        end else begin : g_count
            localparam int PW = $clog2(CLK_DIV);
            localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);
            logic [PW-1:0] pre_q;

            // Divider count, held at zero while disabled.
            always_ff @(posedge clk) begin
                if (!rst_n || !en_i) pre_q <= '0;
                else if (pre_q == LAST) pre_q <= '0;
                else pre_q <= pre_q + 1'b1;
            end

            // Tick on the last divider state, zero flag on the first.
            always_comb begin
                tick_o = en_i && (pre_q == LAST);
                zero_o = (pre_q == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/tg_half_cnt.sv
// Nested half-period counter: the inner count runs over the sample count
// of prescaler ticks per step, the outer count over the step count of
// steps per half period. Flags the half-period end and the midpoint.
// Assumes: limits are 1..8 and 1..64 and stay stable while enabled.
module tg_half_cnt
    import i2c_tg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 tick_i,
    input  logic                 pre_zero_i,
    input  logic [SMP_LIM_W-1:0] smp_lim_i,
    input  logic [STP_LIM_W-1:0] stp_lim_i,
    output logic                 wrap_o,
    output logic                 mid_o,
    output logic [STP_LIM_W-1:0] stp_pos_o
);

    logic [SMP_LIM_W-1:0] smp_q;
    logic [STP_LIM_W-1:0] stp_q;
    logic                 smp_last;
    logic                 stp_last;

    // End-of-count decodes for the two counters.
    always_comb begin
        smp_last = (smp_q == smp_lim_i - 1'b1);
        stp_last = (stp_q == stp_lim_i - 1'b1);
    end

    // Inner counter: advances on each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) smp_q <= '0;
        else if (tick_i) smp_q <= smp_last ? '0 : smp_q + 1'b1;
    end

    // Outer counter: advances when the inner counter wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) stp_q <= '0;
        else if (tick_i && smp_last) stp_q <= stp_last ? '0 : stp_q + 1'b1;
    end

    // Half-period end and midpoint flags.
    always_comb begin
        wrap_o    = tick_i && smp_last && stp_last;
        mid_o     = en_i && pre_zero_i && (smp_q == '0) && (stp_q == (stp_lim_i >> 1));
        stp_pos_o = stp_q;
    end

endmodule

// File: rtl/i2c_scl_timing.sv
// SCL timing generator top. Starts on run_i while idle, toggles SCL at
// each half-period end, stops with SCL released when run_i is low at a
// half-period end, and emits the sample and drive strobes.
// Assumes: CLK_DIV >= 2 so every SCL phase is at least two cycles long.
module i2c_scl_timing
    import i2c_tg_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              run_i,
    input  logic              master_code_i,
    input  logic              std_rate_i,
    output logic              scl_o,
    output logic              busy_o,
    output logic              sample_stb_o,
    output logic              drive_stb_o,
    output logic              hs_active_o,
    output logic [WORD_W-1:0] start_cfg_o
);

    logic                 busy_q;
    logic                 scl_q;
    logic                 fall_d_q;
    logic                 drive_q;
    logic                 start;
    logic                 tick;
    logic                 pre_zero;
    logic                 wrap;
    logic                 mid;
    logic [STP_LIM_W-1:0] stp_pos;
    tg_counts_t           cnt;

    // Run start: request seen while idle.
    always_comb start = run_i && !busy_q;

    tg_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we_i),
        .cfg_sel_i    (cfg_sel_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .master_code_i(master_code_i),
        .std_rate_i   (std_rate_i),
        .load_i       (start),
        .cnt_o        (cnt),
        .hs_active_o  (hs_active_o),
        .start_cfg_o  (start_cfg_o)
    );

    tg_prescale #(.CLK_DIV(CLK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (busy_q),
        .tick_o(tick),
        .zero_o(pre_zero)
    );

    tg_half_cnt u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (busy_q),
        .tick_i    (tick),
        .pre_zero_i(pre_zero),
        .smp_lim_i (cnt.smp),
        .stp_lim_i (cnt.stp),
        .wrap_o    (wrap),
        .mid_o     (mid),
        .stp_pos_o (stp_pos)
    );

    // Run state and SCL level: toggle on each half-period end, release on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            scl_q    <= 1'b1;
            fall_d_q <= 1'b0;
        end else begin
            fall_d_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                scl_q  <= 1'b1;
            end else if (busy_q && wrap) begin
                if (!run_i) begin
                    busy_q <= 1'b0;
                    scl_q  <= 1'b1;
                end else begin
                    scl_q    <= ~scl_q;
                    fall_d_q <= scl_q;
                end
            end
        end
    end

    // Drive strobe: one clock after the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= fall_d_q;
    end

    // Output mapping; sample strobe only in the high phase.
    always_comb begin
        scl_o        = scl_q;
        busy_o       = busy_q;
        drive_stb_o  = drive_q;
        sample_stb_o = mid && scl_q && busy_q;
    end

endmodule

// File: rtl/i2c_scl_timing_chk.sv
// Checker for the SCL timing generator, attached by bind. Watches the
// ports and the captured counts for protocol-level invariants.
module i2c_scl_timing_chk
    import i2c_tg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_o,
    input logic                 busy_o,
    input logic                 sample_stb_o,
    input logic                 drive_stb_o,
    input logic [WORD_W-1:0]    start_cfg_o,
    input logic [SMP_LIM_W-1:0] cnt_smp,
    input logic [STP_LIM_W-1:0] cnt_stp,
    input logic [STP_LIM_W-1:0] stp_pos
);

    // R1: reset leaves SCL released and the generator idle.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (scl_o && !busy_o && !drive_stb_o));

    // R7: the sample strobe appears only during a running high phase.
    a_r7_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> (scl_o && busy_o));

    // R8: a falling SCL edge during a run is followed by the drive strobe.
    a_r8_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_o) && busy_o) |=> drive_stb_o);

    // R8: the drive strobe only appears while SCL is low.
    a_r8_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb_o |-> !scl_o);

    // R9: the captured counts hold for the whole run.
    a_r9_counts_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(cnt_smp) && $stable(cnt_stp)));

    // R10: the setup word is one of the two legal values during a run.
    a_r10_start_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (start_cfg_o == 16'h8001 || start_cfg_o == 16'h1800));

    // R11: SCL is released whenever the generator is idle.
    a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> scl_o);

    // R3: the step position never runs past the captured step count.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (stp_pos < cnt_stp));

endmodule

bind i2c_scl_timing i2c_scl_timing_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_o       (scl_o),
    .busy_o      (busy_o),
    .sample_stb_o(sample_stb_o),
    .drive_stb_o (drive_stb_o),
    .start_cfg_o (start_cfg_o),
    .cnt_smp     (cnt.smp),
    .cnt_stp     (cnt.stp),
    .stp_pos     (stp_pos)
);

// File: tb/i2c_scl_timing_tb_top.sv
// Bench: directed corners plus seeded random timing words; every SCL
// phase and strobe position is timed against values computed here.
module i2c_scl_timing_tb_top;

    localparam int CLK_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_sel_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic        run_i = 1'b0;
    logic        master_code_i = 1'b0;
    logic        std_rate_i = 1'b0;
    logic        scl_o, busy_o, sample_stb_o, drive_stb_o, hs_active_o;
    logic [15:0] start_cfg_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_scl_timing #(.CLK_DIV(CLK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .run_i(run_i), .master_code_i(master_code_i),
        .std_rate_i(std_rate_i), .scl_o(scl_o), .busy_o(busy_o),
        .sample_stb_o(sample_stb_o), .drive_stb_o(drive_stb_o),
        .hs_active_o(hs_active_o), .start_cfg_o(start_cfg_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input bit sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // Expected counts from the register formats in R2/R4/R5/R6.
    function automatic int exp_smp(input logic [15:0] nw, input logic [15:0] hw, input bit mc);
        if (hw[1:0] == 2'b11 && !mc) return int'(hw[14:12]) + 1;
        return int'(nw[10:8]) + 1;
    endfunction
    function automatic int exp_stp(input logic [15:0] nw, input logic [15:0] hw, input bit mc);
        if (hw[1:0] == 2'b11 && !mc) return int'(hw[10:8]) + 1;
        return int'(nw[5:0]) + 1;
    endfunction

    // One run: time the phases and strobes, optionally write during the run.
    task automatic run_case(input logic [15:0] nw, input logic [15:0] hw,
                            input bit mc, input bit std, input bit mid_write,
                            input string req);
        int s = exp_smp(nw, hw, mc);
        int t = exp_stp(nw, hw, mc);
        int h = CLK_DIV * s * t;
        int emid = CLK_DIV * s * (t / 2);
        bit ehs = (hw[1:0] == 2'b11) && !mc;
        int ts = -1, tf = -1, td = -1, tr = -1, tf2 = -1, nstb = 0;
        int stop_wait = 0;
        write_reg(1'b0, nw);
        write_reg(1'b1, hw);
        @(negedge clk);
        master_code_i = mc; std_rate_i = std; run_i = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b1, {req, " busy at start"}, int'(busy_o), 1);
        check(hs_active_o == ehs, {req, " R4 R5 R6 hs_active"}, int'(hs_active_o), int'(ehs));
        check(start_cfg_o == (std ? 16'h8001 : 16'h1800), {req, " R10 start_cfg"},
              int'(start_cfg_o), std ? 32'h8001 : 32'h1800);
        for (int c = 0; c < 4 * h + 20; c++) begin
            if (mid_write && c == 1) begin
                cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 16'h0000;
            end else if (mid_write && c == 2) begin
                cfg_we_i = 1'b1; cfg_sel_i = 1'b1; cfg_wdata_i = 16'h0000;
            end else begin
                cfg_we_i = 1'b0;
            end
            if (sample_stb_o && tf < 0) begin
                if (ts < 0) ts = c;
                nstb++;
            end
            if (!scl_o && tf < 0) tf = c;
            if (drive_stb_o && td < 0) td = c;
            if (scl_o && tf >= 0 && tr < 0) tr = c;
            if (!scl_o && tr >= 0 && tf2 < 0) tf2 = c;
            if (tf2 >= 0) break;
            @(negedge clk);
        end
        cfg_we_i = 1'b0;
        check(tf == h, {req, " R2 high phase"}, tf, h);
        check(tr - tf == h, {req, " R3 low phase"}, tr - tf, h);
        check(tf2 - tr == h, {req, mid_write ? " R9 write ignored" : " R3 second high"}, tf2 - tr, h);
        check(ts == emid, {req, " R7 sample position"}, ts, emid);
        check(nstb == 1, {req, " R7 single sample"}, nstb, 1);
        check(td == tf + 1, {req, " R8 drive position"}, td, tf + 1);
        run_i = 1'b0;
        while (busy_o && stop_wait < 2 * h + 10) begin
            @(negedge clk);
            stop_wait++;
        end
        check(!busy_o && scl_o, {req, " R11 stop released"}, int'({busy_o, scl_o}), 1);
        check(stop_wait <= h + 1, {req, " R11 stop latency"}, stop_wait, h + 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= 190000 || done);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] nw, hw;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(scl_o && !busy_o && !sample_stb_o && !drive_stb_o && !hs_active_o,
              "R1 reset outputs", int'({scl_o, busy_o, sample_stb_o, drive_stb_o, hs_active_o}), 16);
        // R1: default counts give a 2-cycle phase.
        run_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(!scl_o, "R1 default phase", int'(scl_o), 0);
        run_i = 1'b0;
        repeat (6) @(negedge clk);
        // Directed corners.
        run_case(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, "R2 min");
        run_case(16'h073F, 16'h0000, 1'b0, 1'b1, 1'b0, "R2 max");
        run_case(16'h0205, 16'h0001, 1'b0, 1'b0, 1'b0, "R5 hs off");
        run_case(16'h1303, 16'h7703, 1'b0, 1'b0, 1'b0, "R4 hs max");
        run_case(16'h1303, 16'h0003, 1'b0, 1'b0, 1'b0, "R4 hs min");
        run_case(16'h1303, 16'h3503, 1'b1, 1'b0, 1'b0, "R6 preamble");
        run_case(16'h0407, 16'h0000, 1'b0, 1'b1, 1'b1, "R9 busy write");
        // Seeded random words.
        for (int i = 0; i < 14; i++) begin
            nw = 16'($urandom);
            nw[5] = 1'b0;
            hw = 16'($urandom);
            if (i % 2 == 0) hw[1:0] = 2'b11;
            run_case(nw, hw, 1'($urandom), 1'($urandom), 1'($urandom), "rand R2 R4");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule